// File: doc/BRIEF.md
# Radix-Adjusted Nibble Add-With-Carry Unit

This unit executes two memory-destination add-with-carry operations for a 4-bit data path. It decodes a 13-bit instruction word. One form adds the B operand and the incoming carry to the nibble addressed by pointer X or pointer Y, writes the result back, and asks for that pointer to be advanced by one. The other form adds only the carry to the addressed nibble and leaves the pointer alone. This second form is the usual way to ripple a carry into the most significant digit of a counter kept in an arbitrary radix.

Every result is folded into a radix between 1 and 16 that the instruction's low nibble carries. The unit owns the read-modify-write over a synchronous nibble memory port. It reports new C and Z values to the surrounding register file, together with the post-incremented pointer value. A one-shot extension register, loaded beforehand with an 8-bit immediate, redirects the carry-only form to a fixed page: the bottom page when X is named, the top page when Y is named.

Top module: `nibble_radix_adc`

## Requirements
- R1: Only these instruction words are executed: bits [12:4] equal to 0x1D5 (B+carry into [X], post-increment), 0x1D7 (same with [Y]), 0x1D0 (carry only into [X]) or 0x1D2 (carry only into [Y]). Any other word accepted on `start` produces no memory read, no memory write, no `done`, and leaves `busy` low.
- R2: The radix is 16 minus bits [3:0] of the instruction, so a field of 0 selects radix 16 and a field of 0xF selects radix 1.
- R3: The post-increment form writes adjust(mem+B+C) to the pointer's address. In the same cycle it asserts `ptr_we`, drives `ptr_is_y` high for Y and low for X, and drives `ptr_next` to the pointer plus one, wrapping from 0xFFFF to 0x0000.
- R4: The carry-only form writes adjust(mem+0+C) to the addressed nibble and keeps `ptr_we` low.
- R5: Adjust rule: if the raw sum is at least the radix, the written value is (sum − radix) modulo 16 and C is 1. Otherwise the sum is written and C is 0. Operands at or above the radix are not range-checked.
- R6: Z is 1 exactly when the written nibble is 0.
- R7: An accepted, valid instruction drives `mem_rd` and its address in the accept cycle. In the next cycle it drives `mem_we`, `flag_we` and `done` for one cycle, and `busy` is high in that cycle. A `start` seen while busy is ignored.
- R8: After `ext_load`, the next carry-only instruction addresses {0x00, imm} for X or {0xFF, imm} for Y, and neither pointer is used.
- R9: The extension is cleared by the next accepted `start`, whatever that instruction is. The post-increment form never uses it and always addresses through its pointer.
- R10: C and Z come from the memory result only. They are not affected by the pointer increment, including the wrap to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Present an instruction (accepted when idle) |
| instr | input | 13 | Instruction word |
| x_ptr | input | 16 | Current X pointer |
| y_ptr | input | 16 | Current Y pointer |
| b_val | input | 4 | Current B register |
| c_in | input | 1 | Current carry flag |
| ext_load | input | 1 | Load the extension immediate |
| ext_imm | input | 8 | Extension immediate |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 4 | Memory write data |
| mem_rdata | input | 4 | Memory read data, valid the cycle after `mem_rd` |
| flag_we | output | 1 | Flag update strobe |
| c_out | output | 1 | New carry flag |
| z_out | output | 1 | New zero flag |
| ptr_we | output | 1 | Pointer update strobe |
| ptr_is_y | output | 1 | Pointer update targets Y (1) or X (0) |
| ptr_next | output | 16 | Incremented pointer value |
| busy | output | 1 | Write-back cycle in progress |
| done | output | 1 | Instruction completes this cycle |

## Verification
The hardest state to reach is the one-shot extension. Its effect depends on which instruction comes next: the carry-only form consumes it, the post-increment form and invalid words only discard it. To cover this, the stimulus loads an immediate and then issues each of those three kinds in turn. Each time it follows with a plain carry-only instruction and checks that the address is back on the pointer. The other hard cases are radix boundaries with out-of-range operands, which the stimulus hits by preloading memory values above the radix, and a pointer at 0xFFFF whose wrap must leave Z clear.

// File: rtl/nra_pkg.sv
package nra_pkg;

   typedef enum logic [1:0] {
      OP_NONE      = 2'd0,
      OP_ADD_B_INC = 2'd1,
      OP_ADD_C     = 2'd2
   } op_kind_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WB   = 1'b1
   } seq_state_e;

endpackage

// File: rtl/nra_decode.sv
module nra_decode
   import nra_pkg::*;
#(
   parameter int INSTR_W = 13,
   parameter int DATA_W  = 4,
   localparam int OPC_W  = INSTR_W - DATA_W,
   parameter logic [OPC_W-1:0] OPC_ADDB_X = 'h1D5,
   parameter logic [OPC_W-1:0] OPC_ADDB_Y = 'h1D7,
   parameter logic [OPC_W-1:0] OPC_ADDC_X = 'h1D0,
   parameter logic [OPC_W-1:0] OPC_ADDC_Y = 'h1D2
) (
   input  logic [INSTR_W-1:0] instr,
   output op_kind_e           kind,
   output logic               use_y,
   output logic [DATA_W:0]    radix
);

   localparam logic [DATA_W:0] RADIX_TOP = (DATA_W+1)'(1) << DATA_W;

   logic [OPC_W-1:0] opc;
   assign opc   = instr[INSTR_W-1:DATA_W];
   assign radix = RADIX_TOP - {1'b0, instr[DATA_W-1:0]};

   always_comb begin
      kind  = OP_NONE;
      use_y = 1'b0;
      unique case (opc)
         OPC_ADDB_X: kind = OP_ADD_B_INC;
         OPC_ADDB_Y: begin kind = OP_ADD_B_INC; use_y = 1'b1; end
         OPC_ADDC_X: kind = OP_ADD_C;
         OPC_ADDC_Y: begin kind = OP_ADD_C; use_y = 1'b1; end
         default:    kind = OP_NONE;
      endcase
   end

endmodule

// File: rtl/nra_radix_adj.sv
module nra_radix_adj #(
   parameter int DATA_W   = 4,
   parameter int ADJ_IMPL = 0
) (
   input  logic [DATA_W-1:0] mem_val,
   input  logic [DATA_W-1:0] addend,
   input  logic              cin,
   input  logic [DATA_W:0]   radix,
   output logic [DATA_W-1:0] result,
   output logic              cout
);

   logic [DATA_W:0] raw_sum;
   assign raw_sum = {1'b0, mem_val} + {1'b0, addend} + {{DATA_W{1'b0}}, cin};

   generate
      if (ADJ_IMPL == 0) begin : g_compare
         assign cout   = (raw_sum >= radix);
         assign result = cout ? DATA_W'(raw_sum - radix) : DATA_W'(raw_sum);
      end else if (ADJ_IMPL == 1) begin : g_borrow
         logic [DATA_W+1:0] diff;
         assign diff   = {1'b0, raw_sum} - {1'b0, radix};
         assign cout   = ~diff[DATA_W+1];
         assign result = cout ? DATA_W'(diff) : DATA_W'(raw_sum);
      end else begin : g_bad_impl
         $error("nra_radix_adj: ADJ_IMPL must be 0 or 1");
      end
   endgenerate

endmodule

// File: rtl/nra_addr_gen.sv
module nra_addr_gen #(
   parameter int ADDR_W = 16,
   parameter int EXT_W  = 8
) (
   input  logic              use_ext,
   input  logic              use_y,
   input  logic [ADDR_W-1:0] x_ptr,
   input  logic [ADDR_W-1:0] y_ptr,
   input  logic [EXT_W-1:0]  ext_val,
   output logic [ADDR_W-1:0] addr
);

   localparam int PAGE_W = ADDR_W - EXT_W;

   logic [ADDR_W-1:0] page_addr;
   assign page_addr = {{PAGE_W{use_y}}, ext_val};

   always_comb begin
      if (use_ext)    addr = page_addr;
      else if (use_y) addr = y_ptr;
      else            addr = x_ptr;
   end

endmodule

// File: rtl/nibble_radix_adc.sv
module nibble_radix_adc
   import nra_pkg::*;
#(
   parameter int DATA_W   = 4,
   parameter int ADDR_W   = 16,
   parameter int EXT_W    = 8,
   parameter int INSTR_W  = 13,
   parameter int ADJ_IMPL = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [INSTR_W-1:0] instr,
   input  logic [ADDR_W-1:0]  x_ptr,
   input  logic [ADDR_W-1:0]  y_ptr,
   input  logic [DATA_W-1:0]  b_val,
   input  logic               c_in,
   input  logic               ext_load,
   input  logic [EXT_W-1:0]   ext_imm,
   output logic               mem_rd,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               flag_we,
   output logic               c_out,
   output logic               z_out,
   output logic               ptr_we,
   output logic               ptr_is_y,
   output logic [ADDR_W-1:0]  ptr_next,
   output logic               busy,
   output logic               done
);

   generate
      if (DATA_W < 2)          begin : g_chk_data  $error("DATA_W must be at least 2");        end
      if (INSTR_W <= DATA_W)   begin : g_chk_instr $error("INSTR_W must exceed DATA_W");       end
      if (EXT_W >= ADDR_W)     begin : g_chk_ext   $error("EXT_W must be narrower than ADDR_W"); end
   endgenerate

   // decode of the presented word
   op_kind_e          dec_kind;
   logic              dec_use_y;
   logic [DATA_W:0]   dec_radix;

   nra_decode #(.INSTR_W(INSTR_W), .DATA_W(DATA_W)) u_decode (
      .instr (instr),
      .kind  (dec_kind),
      .use_y (dec_use_y),
      .radix (dec_radix)
   );

   // sequencing and latched operands
   seq_state_e        state_q;
   logic              ext_on_q;
   logic [EXT_W-1:0]  ext_val_q;
   op_kind_e          kind_q;
   logic              use_y_q;
   logic [DATA_W:0]   radix_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] addend_q;
   logic              cin_q;

   logic accept, op_ok, use_ext, in_wb;
   logic [ADDR_W-1:0] cur_addr;

   assign in_wb   = (state_q == ST_WB);
   assign accept  = (state_q == ST_IDLE) && start;
   assign op_ok   = accept && (dec_kind != OP_NONE);
   assign use_ext = ext_on_q && (dec_kind == OP_ADD_C);

   nra_addr_gen #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_addr (
      .use_ext (use_ext),
      .use_y   (dec_use_y),
      .x_ptr   (x_ptr),
      .y_ptr   (y_ptr),
      .ext_val (ext_val_q),
      .addr    (cur_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         ext_on_q  <= 1'b0;
         ext_val_q <= '0;
         kind_q    <= OP_NONE;
         use_y_q   <= 1'b0;
         radix_q   <= '0;
         addr_q    <= '0;
         addend_q  <= '0;
         cin_q     <= 1'b0;
      end else begin
         if (accept) begin
            ext_on_q <= 1'b0;
         end else if (ext_load) begin
            ext_on_q  <= 1'b1;
            ext_val_q <= ext_imm;
         end
         if (op_ok) begin
            state_q  <= ST_WB;
            kind_q   <= dec_kind;
            use_y_q  <= dec_use_y;
            radix_q  <= dec_radix;
            addr_q   <= cur_addr;
            addend_q <= (dec_kind == OP_ADD_B_INC) ? b_val : '0;
            cin_q    <= c_in;
         end else if (in_wb) begin
            state_q  <= ST_IDLE;
         end
      end
   end

   // radix-adjusted sum in the write-back cycle
   logic [DATA_W-1:0] adj_res;
   logic              adj_c;

   nra_radix_adj #(.DATA_W(DATA_W), .ADJ_IMPL(ADJ_IMPL)) u_adj (
      .mem_val (mem_rdata),
      .addend  (addend_q),
      .cin     (cin_q),
      .radix   (radix_q),
      .result  (adj_res),
      .cout    (adj_c)
   );

   assign mem_rd    = op_ok;
   assign mem_addr  = in_wb ? addr_q : cur_addr;
   assign mem_we    = in_wb;
   assign mem_wdata = adj_res;
   assign flag_we   = in_wb;
   assign c_out     = adj_c;
   assign z_out     = (adj_res == '0);
   assign ptr_we    = in_wb && (kind_q == OP_ADD_B_INC);
   assign ptr_is_y  = use_y_q;
   assign ptr_next  = addr_q + ADDR_W'(1);
   assign busy      = in_wb;
   assign done      = in_wb;

   // R7: a read is always followed by the write-back one cycle later
   assert_read_then_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (mem_we && done && flag_we));

   // R7: completion only ever follows an issued read
   assert_done_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_rd));

   // R1: a read is never issued while a write-back is running
   assert_no_rd_during_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_we));

   // R6 / R10: zero flag follows the written nibble only
   assert_zero_tracks_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |-> (z_out == (mem_wdata == '0)));

   // R3: the pointer offered back is the written address plus one
   assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_we |-> (ptr_next == ADDR_W'(mem_addr + ADDR_W'(1))));

   // R4: pointer updates only accompany a memory write
   assert_ptr_only_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_we |-> mem_we);

endmodule

// File: tb/nibble_radix_adc_tb_top.sv
module nibble_radix_adc_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [12:0] instr = '0;
   logic [15:0] x_ptr = '0;
   logic [15:0] y_ptr = '0;
   logic [3:0]  b_val = '0;
   logic        c_in = 1'b0;
   logic        ext_load = 1'b0;
   logic [7:0]  ext_imm = '0;
   logic        mem_rd, mem_we, flag_we, c_out, z_out, ptr_we, ptr_is_y, busy, done;
   logic [15:0] mem_addr, ptr_next;
   logic [3:0]  mem_wdata;
   logic [3:0]  mem_rdata = '0;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nibble_radix_adc dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .x_ptr(x_ptr), .y_ptr(y_ptr), .b_val(b_val), .c_in(c_in),
      .ext_load(ext_load), .ext_imm(ext_imm),
      .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .flag_we(flag_we), .c_out(c_out), .z_out(z_out),
      .ptr_we(ptr_we), .ptr_is_y(ptr_is_y), .ptr_next(ptr_next),
      .busy(busy), .done(done)
   );

   // synchronous nibble memory model
   logic [3:0] mem_img [logic [15:0]];
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem_img.exists(mem_addr) ? mem_img[mem_addr] : 4'h0;
      if (mem_we) mem_img[mem_addr] = mem_wdata;
   end

   typedef struct {
      logic [15:0] addr;
      logic [3:0]  data;
      logic        c;
      logic        z;
      logic        pwe;
      logic        py;
      logic [15:0] pnext;
      string       req;
   } exp_item_t;

   exp_item_t sb_q[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // monitor: compare each completion against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            if (sb_q.size() == 0) begin
               chk(1'b0, "R1", "unexpected done", 32'd1, 32'd0);
            end else begin
               exp_item_t e;
               e = sb_q.pop_front();
               chk(mem_we && flag_we && busy, e.req, "wb strobes", {mem_we, flag_we, busy}, 3'b111);
               chk(mem_addr == e.addr, e.req, "wb addr", mem_addr, e.addr);
               chk(mem_wdata == e.data, e.req, "data", mem_wdata, e.data);
               chk(c_out == e.c, e.req, "carry", c_out, e.c);
               chk(z_out == e.z, e.req, "zero", z_out, e.z);
               chk(ptr_we == e.pwe, e.req, "ptr_we", ptr_we, e.pwe);
               if (e.pwe) begin
                  chk(ptr_is_y == e.py, e.req, "ptr_is_y", ptr_is_y, e.py);
                  chk(ptr_next == e.pnext, e.req, "ptr_next", ptr_next, e.pnext);
               end
            end
         end else if (mem_we) begin
            chk(1'b0, "R7", "write without done", 32'd1, 32'd0);
         end
      end
   end

   // driver: issue one instruction, predict its result
   task automatic run_op(input logic [12:0] ins, input logic [15:0] x, input logic [15:0] y,
                         input logic [3:0] b, input logic c, input logic [3:0] mval,
                         input bit ext_live, input logic [7:0] imm, input string req,
                         input bit hold_busy = 0);
      logic [8:0]  hi;
      bit          valid, addb, usey;
      int          n, s;
      logic [15:0] addr;
      exp_item_t   e;
      hi    = ins[12:4];
      addb  = (hi == 9'h1D5) || (hi == 9'h1D7);
      usey  = (hi == 9'h1D7) || (hi == 9'h1D2);
      valid = addb || (hi == 9'h1D0) || (hi == 9'h1D2);
      n     = 16 - int'(ins[3:0]);
      if (ext_live && valid && !addb) addr = {usey ? 8'hFF : 8'h00, imm};
      else                            addr = usey ? y : x;
      s = int'(mval) + (addb ? int'(b) : 0) + int'(c);
      if (valid) begin
         mem_img[addr] = mval;
         e.addr  = addr;
         e.c     = (s >= n);
         e.data  = e.c ? 4'((s - n) % 16) : 4'(s);
         e.z     = (e.data == 4'h0);
         e.pwe   = addb;
         e.py    = usey;
         e.pnext = addr + 16'd1;
         e.req   = req;
         sb_q.push_back(e);
      end
      @(negedge clk);
      instr = ins; x_ptr = x; y_ptr = y; b_val = b; c_in = c; start = 1'b1;
      #1;
      chk(mem_rd == valid, req, "mem_rd at accept", mem_rd, valid);
      if (valid) chk(mem_addr == addr, req, "read address", mem_addr, addr);
      @(negedge clk);
      if (hold_busy) begin
         // R7: present another valid word while busy; it must be dropped
         instr = 13'h1D23;
         chk(busy == 1'b1, "R7", "busy in write-back", busy, 1'b1);
         @(negedge clk);
      end
      start = 1'b0;
      if (!valid) begin
         chk(!busy && !done && !mem_we, req, "invalid word idle", {busy, done, mem_we}, 3'b000);
      end
   endtask

   task automatic load_ext(input logic [7:0] v);
      @(negedge clk);
      ext_load = 1'b1; ext_imm = v;
      @(negedge clk);
      ext_load = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      chk(1'b0, "WDOG", "watchdog expired", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({mem_rd, mem_we, busy, done, flag_we, ptr_we} == 6'b0, "R7", "reset outputs",
          {mem_rd, mem_we, busy, done, flag_we, ptr_we}, 6'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 / R5: radix 10, no carry out
      run_op(13'h1D56, 16'h0100, 16'h0000, 4'd3, 1'b0, 4'd4, 0, 8'h00, "R3");
      // R3 / R6: Y pointer, radix 10 exact roll to zero
      run_op(13'h1D76, 16'h0000, 16'h2000, 4'd0, 1'b1, 4'd9, 0, 8'h00, "R6");
      // R4: carry-only into X, radix 10
      run_op(13'h1D06, 16'h0300, 16'h0000, 4'd7, 1'b1, 4'd9, 0, 8'h00, "R4");
      // R2: radix 16 encoded as field 0
      run_op(13'h1D20, 16'h0000, 16'h0400, 4'd0, 1'b1, 4'hF, 0, 8'h00, "R2");
      run_op(13'h1D50, 16'h0500, 16'h0000, 4'hF, 1'b1, 4'hF, 0, 8'h00, "R2");
      // R2: radix 1 encoded as field F
      run_op(13'h1D0F, 16'h0600, 16'h0000, 4'd0, 1'b0, 4'd0, 0, 8'h00, "R2");
      run_op(13'h1D5F, 16'h0700, 16'h0000, 4'd0, 1'b1, 4'd0, 0, 8'h00, "R2");
      // R5: operands above the radix, single subtract modulo 16
      run_op(13'h1D56, 16'h0800, 16'h0000, 4'd9, 1'b1, 4'd12, 0, 8'h00, "R5");
      run_op(13'h1D0A, 16'h0900, 16'h0000, 4'd0, 1'b1, 4'd8, 0, 8'h00, "R5");
      // R10: pointer wraps to zero, flags follow data
      run_op(13'h1D70, 16'h0000, 16'hFFFF, 4'd3, 1'b0, 4'd2, 0, 8'h00, "R10");
      // R1: words outside the four groups
      run_op(13'h1D16, 16'h0A00, 16'h0000, 4'd1, 1'b1, 4'd1, 0, 8'h00, "R1");
      run_op(13'h1D66, 16'h0A00, 16'h0000, 4'd1, 1'b1, 4'd1, 0, 8'h00, "R1");
      run_op(13'h0D56, 16'h0A00, 16'h0000, 4'd1, 1'b1, 4'd1, 0, 8'h00, "R1");
      // R8: extension into bottom page (X) and top page (Y)
      load_ext(8'h34);
      run_op(13'h1D06, 16'h1234, 16'h0000, 4'd0, 1'b1, 4'd5, 1, 8'h34, "R8");
      load_ext(8'h56);
      run_op(13'h1D20, 16'h0000, 16'h4321, 4'd0, 1'b1, 4'd3, 1, 8'h56, "R8");
      // R9: consumed extension does not persist
      run_op(13'h1D06, 16'h1234, 16'h0000, 4'd0, 1'b1, 4'd2, 0, 8'h00, "R9");
      // R9: post-increment form ignores and clears the extension
      load_ext(8'h77);
      run_op(13'h1D56, 16'h0B00, 16'h0000, 4'd2, 1'b0, 4'd1, 0, 8'h00, "R9");
      run_op(13'h1D06, 16'h0B10, 16'h0000, 4'd0, 1'b1, 4'd1, 0, 8'h00, "R9");
      // R9: invalid word also clears the extension
      load_ext(8'h88);
      run_op(13'h1D36, 16'h0C00, 16'h0000, 4'd0, 1'b1, 4'd1, 0, 8'h00, "R9");
      run_op(13'h1D20, 16'h0000, 16'h0C20, 4'd0, 1'b1, 4'd6, 0, 8'h00, "R9");
      // R7: start held through write-back is not taken again
      run_op(13'h1D56, 16'h0D00, 16'h0000, 4'd1, 1'b0, 4'd1, 0, 8'h00, "R7", 1);

      repeat (4) @(negedge clk);
      chk(sb_q.size() == 0, "R7", "pending completions", sb_q.size(), 0);
      finish_run();
   end

endmodule